// File: doc/BRIEF.md
# Reset Strap Boot Configuration Loader

This block decides the initial configuration of a processor subsystem while the system comes out of reset. Three strap pins are sampled while reset is held. Their value either selects one of four built-in configuration sets, or tells the block to fetch the configuration from a serial EEPROM. When fetching, the block acts as a two-wire I2C bus master. The straps also pick which of two 7-bit slave addresses the EEPROM answers on.

The configuration ends up in four 32-bit setup registers. A done flag rises once they are valid. A processor-start enable stays low until then, so the core cannot run on half-loaded settings. If the EEPROM fails to answer, the block falls back to the first built-in set and flags an error.

Top module: `boot_strap_loader`

## Requirements
- R1: The strap inputs are captured at the last rising clock edge at which `rst_n` is low. Any change on the straps after reset is released has no effect on the outputs.
- R2: The strap code `strap_i[2:0]` decodes as follows. 000 fetches from address `ADDR_SEL0` (default 0x54). 001 and 011 fetch from `ADDR_SEL1` (default 0x50). 010 selects built-in set A, 100 set B, 101 set C and 111 set D. The spare code 110 selects set A.
- R3: On a built-in selection, the setup registers take the chosen set and `done_o` is high after the first clock edge following reset release. It is low before that edge. Neither bus line is driven.
- R4: A fetch is one random read. The block sends START, the address with write bit 0, word address `WORD_ADDR` (0x00), a repeated START, the address with read bit 1, then 16 data bytes, then STOP. The master ACKs bytes 1 to 15 and NACKs byte 16.
- R5: The fetched bytes fill `cfg0_o` to `cfg3_o` in order, four bytes each, most significant byte first. The first byte lands in `cfg0_o[31:24]`.
- R6: A NACK to either address byte or to the word address ends the transfer with STOP. It then loads set A, sets `err_o` and sets `done_o`.
- R7: `cpu_start_en_o` is low while `done_o` is low. Once `done_o` is high, it and the registers hold until the next reset.
- R8: An SCL period inside a byte is 4×`QTR_CYC` clocks. SDA changes only while SCL is low, except for START and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| strap_i | input | 3 | Configuration strap pins |
| scl_pull_o | output | 1 | 1 pulls the SCL line low (open drain) |
| sda_pull_o | output | 1 | 1 pulls the SDA line low (open drain) |
| sda_i | input | 1 | Sensed SDA line level |
| cfg0_o | output | 32 | Setup register 0 |
| cfg1_o | output | 32 | Setup register 1 |
| cfg2_o | output | 32 | Setup register 2 |
| cfg3_o | output | 32 | Setup register 3 |
| done_o | output | 1 | Configuration valid |
| err_o | output | 1 | EEPROM did not acknowledge, fallback used |
| cpu_start_en_o | output | 1 | Processor start permission |

## Verification
The bench builds the loader with `QTR_CYC` = 4. That gives a 16-clock SCL period, so a full 22-operation fetch completes in a few thousand cycles and every strap code can be run in one session. The built-in sets and both slave addresses keep their default values. This lets the bench's EEPROM model test address matching on 0x54 and on 0x50, and a mismatched address produces the NACK fallback.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

   typedef enum logic [2:0] {
      PC_NONE,
      PC_START,
      PC_STOP,
      PC_WRITE,
      PC_READ
   } phy_cmd_e;

   typedef enum logic [1:0] {
      SET_A,
      SET_B,
      SET_C,
      SET_D
   } dflt_set_e;

   typedef struct packed {
      logic      fetch;
      logic      alt_addr;
      dflt_set_e set;
   } strap_mode_t;

   // Strap code to mode (code is {s2,s1,s0})
   function automatic strap_mode_t decode_strap(input logic [2:0] s);
      strap_mode_t m;
      m.fetch    = 1'b0;
      m.alt_addr = 1'b0;
      m.set      = SET_A;
      if (s == 3'b000) begin
         m.fetch = 1'b1;
      end else if (!s[2] && s[0]) begin
         m.fetch    = 1'b1;
         m.alt_addr = 1'b1;
      end else begin
         case (s)
            3'b100:  m.set = SET_B;
            3'b101:  m.set = SET_C;
            3'b111:  m.set = SET_D;
            default: m.set = SET_A;
         endcase
      end
      return m;
   endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch
   import bsl_pkg::*;
#(
   parameter int STRAP_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_i,
   output strap_mode_t        mode_o
);

   logic [STRAP_W-1:0] raw_q;
   logic               run_q;

   generate
      if (STRAP_W != 3) begin : g_bad_w
         $error("strap_latch: decoder expects three strap pins");
      end
   endgenerate

   // Loads on every edge while reset is low; frozen afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= strap_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   assign mode_o = decode_strap(raw_q);

   p_strap_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> $stable(raw_q));

endmodule

// File: rtl/i2c_byte_phy.sv
module i2c_byte_phy
   import bsl_pkg::*;
#(
   parameter int QTR_CYC = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  phy_cmd_e   cmd_i,
   input  logic [7:0] tx_byte_i,
   input  logic       ack_tx_i,
   output logic       done_o,
   output logic [7:0] rx_byte_o,
   output logic       ack_rx_o,
   output logic       scl_low_o,
   output logic       sda_low_o,
   input  logic       sda_i
);

   localparam int QW = (QTR_CYC > 2) ? $clog2(QTR_CYC) : 1;
   localparam logic [QW-1:0] QLAST = QW'(QTR_CYC - 1);

   generate
      if (QTR_CYC < 2) begin : g_bad_qtr
         $error("i2c_byte_phy: QTR_CYC must be at least 2");
      end
   endgenerate

   phy_cmd_e    op_q;
   logic [QW-1:0] qcnt_q;
   logic [1:0]  phase_q;
   logic [3:0]  bit_q;
   logic [7:0]  tx_q;
   logic [7:0]  rx_q;
   logic        ackrx_q;
   logic        ackt_q;
   logic        scl_low_q;
   logic        sda_low_q;
   logic        done_q;
   logic [3:0]  bit_nx;

   assign bit_nx = bit_q + 4'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= PC_NONE;
         qcnt_q    <= '0;
         phase_q   <= '0;
         bit_q     <= '0;
         tx_q      <= '0;
         rx_q      <= '0;
         ackrx_q   <= 1'b0;
         ackt_q    <= 1'b0;
         scl_low_q <= 1'b0;
         sda_low_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (op_q == PC_NONE) begin
            if (cmd_i != PC_NONE) begin
               op_q    <= cmd_i;
               qcnt_q  <= '0;
               phase_q <= '0;
               bit_q   <= '0;
               case (cmd_i)
                  PC_START: sda_low_q <= 1'b0;
                  PC_STOP:  sda_low_q <= 1'b1;
                  PC_WRITE: begin
                     tx_q      <= tx_byte_i;
                     sda_low_q <= ~tx_byte_i[7];
                  end
                  default: begin
                     ackt_q    <= ack_tx_i;
                     sda_low_q <= 1'b0;
                  end
               endcase
            end
         end else if (qcnt_q != QLAST) begin
            qcnt_q <= qcnt_q + QW'(1);
         end else begin
            qcnt_q  <= '0;
            phase_q <= phase_q + 2'd1;
            case (phase_q)
               2'd0: scl_low_q <= 1'b0;
               2'd1: begin
                  if (op_q == PC_START)     sda_low_q <= 1'b1;
                  else if (op_q == PC_STOP) sda_low_q <= 1'b0;
                  else if (bit_q < 4'd8)    rx_q      <= {rx_q[6:0], sda_i};
                  else                      ackrx_q   <= ~sda_i;
               end
               2'd2: if (op_q != PC_STOP) scl_low_q <= 1'b1;
               default: begin
                  if (op_q == PC_START || op_q == PC_STOP || bit_q == 4'd8) begin
                     op_q   <= PC_NONE;
                     done_q <= 1'b1;
                  end else begin
                     bit_q <= bit_nx;
                     if (op_q == PC_WRITE) begin
                        tx_q      <= {tx_q[6:0], 1'b0};
                        sda_low_q <= (bit_nx == 4'd8) ? 1'b0 : ~tx_q[6];
                     end else begin
                        sda_low_q <= (bit_nx == 4'd8) ? ackt_q : 1'b0;
                     end
                  end
               end
            endcase
         end
      end
   end

   assign done_o    = done_q;
   assign rx_byte_o = rx_q;
   assign ack_rx_o  = ackrx_q;
   assign scl_low_o = scl_low_q;
   assign sda_low_o = sda_low_q;

   // SDA steady while SCL high during data/ack bits
   p_sda_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_q == PC_WRITE || op_q == PC_READ) && !scl_low_q && !$past(scl_low_q))
         |-> $stable(sda_low_q));

   // Commands only arrive while idle
   p_cmd_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i != PC_NONE) |-> (op_q == PC_NONE));

endmodule

// File: rtl/boot_fetch_seq.sv
module boot_fetch_seq
   import bsl_pkg::*;
#(
   parameter int          NBYTES    = 16,
   parameter logic [7:0]  WORD_ADDR = 8'h00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [6:0]          addr7_i,
   output phy_cmd_e            cmd_o,
   output logic [7:0]          tx_byte_o,
   output logic                ack_tx_o,
   input  logic                phy_done_i,
   input  logic [7:0]          rx_byte_i,
   input  logic                ack_rx_i,
   output logic [8*NBYTES-1:0] cfg_o,
   output logic                fin_o,
   output logic                err_o
);

   localparam int CW = (NBYTES > 2) ? $clog2(NBYTES) : 1;
   localparam logic [CW-1:0] CLAST = CW'(NBYTES - 1);

   generate
      if (NBYTES < 1) begin : g_bad_n
         $error("boot_fetch_seq: NBYTES must be positive");
      end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_ST1, S_AW, S_WA, S_ST2, S_AR, S_RD, S_SP, S_END
   } seq_st_e;

   seq_st_e             st_q;
   logic                pend_q;
   logic [CW-1:0]       cnt_q;
   logic [8*NBYTES-1:0] cfg_q;
   logic                err_q;
   logic                fin_q;

   always_comb begin
      cmd_o = PC_NONE;
      if (pend_q) begin
         case (st_q)
            S_ST1, S_ST2:  cmd_o = PC_START;
            S_AW, S_WA, S_AR: cmd_o = PC_WRITE;
            S_RD:          cmd_o = PC_READ;
            S_SP:          cmd_o = PC_STOP;
            default:       cmd_o = PC_NONE;
         endcase
      end
   end

   always_comb begin
      case (st_q)
         S_AW:    tx_byte_o = {addr7_i, 1'b0};
         S_AR:    tx_byte_o = {addr7_i, 1'b1};
         default: tx_byte_o = WORD_ADDR;
      endcase
   end

   assign ack_tx_o = (cnt_q != CLAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         pend_q <= 1'b0;
         cnt_q  <= '0;
         cfg_q  <= '0;
         err_q  <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (cmd_o != PC_NONE) pend_q <= 1'b0;
         if (st_q == S_IDLE) begin
            if (start_i) begin
               st_q   <= S_ST1;
               pend_q <= 1'b1;
            end
         end else if (phy_done_i) begin
            pend_q <= 1'b1;
            case (st_q)
               S_ST1: st_q <= S_AW;
               S_AW: begin
                  st_q  <= ack_rx_i ? S_WA : S_SP;
                  err_q <= ~ack_rx_i;
               end
               S_WA: begin
                  st_q  <= ack_rx_i ? S_ST2 : S_SP;
                  err_q <= ~ack_rx_i;
               end
               S_ST2: st_q <= S_AR;
               S_AR: begin
                  st_q  <= ack_rx_i ? S_RD : S_SP;
                  err_q <= ~ack_rx_i;
               end
               S_RD: begin
                  cfg_q <= {cfg_q[8*NBYTES-9:0], rx_byte_i};
                  cnt_q <= cnt_q + CW'(1);
                  if (cnt_q == CLAST) st_q <= S_SP;
               end
               S_SP: begin
                  st_q   <= S_END;
                  pend_q <= 1'b0;
                  fin_q  <= 1'b1;
               end
               default: pend_q <= 1'b0;
            endcase
         end
      end
   end

   assign cfg_o = cfg_q;
   assign fin_o = fin_q;
   assign err_o = err_q;

   // A refused address byte never leads on to the data phase
   p_err_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (st_q == S_SP || st_q == S_END));

   // The finish pulse always follows a STOP
   p_fin_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |-> (st_q == S_END && $past(st_q) == S_SP));

endmodule

// File: rtl/boot_strap_loader.sv
module boot_strap_loader
   import bsl_pkg::*;
#(
   parameter int           QTR_CYC   = 8,
   parameter logic [6:0]   ADDR_SEL0 = 7'h54,
   parameter logic [6:0]   ADDR_SEL1 = 7'h50,
   parameter logic [7:0]   WORD_ADDR = 8'h00,
   parameter int           CFG_W     = 32,
   parameter logic [4*CFG_W-1:0] SET_A_CFG = 128'h8000_0000_0000_1100_0000_0000_2000_0001,
   parameter logic [4*CFG_W-1:0] SET_B_CFG = 128'h4000_0000_0001_2200_0000_0000_2000_0002,
   parameter logic [4*CFG_W-1:0] SET_C_CFG = 128'hC000_0000_0002_3300_0000_0000_4000_0004,
   parameter logic [4*CFG_W-1:0] SET_D_CFG = 128'h2000_0000_0003_4400_0000_0000_4000_0008
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       strap_i,
   output logic             scl_pull_o,
   output logic             sda_pull_o,
   input  logic             sda_i,
   output logic [CFG_W-1:0] cfg0_o,
   output logic [CFG_W-1:0] cfg1_o,
   output logic [CFG_W-1:0] cfg2_o,
   output logic [CFG_W-1:0] cfg3_o,
   output logic             done_o,
   output logic             err_o,
   output logic             cpu_start_en_o
);

   localparam int NREG   = 4;
   localparam int TOTW   = NREG * CFG_W;
   localparam int NBYTES = TOTW / 8;

   generate
      if (CFG_W % 8 != 0 || CFG_W < 8) begin : g_bad_cfgw
         $error("boot_strap_loader: CFG_W must be a whole number of bytes");
      end
   endgenerate

   typedef enum logic [1:0] {T_INIT, T_FETCH, T_DONE} top_st_e;

   strap_mode_t      mode;
   top_st_e          st_q;
   logic [TOTW-1:0]  cfg_q;
   logic             done_q;
   logic             err_q;
   logic             start;
   phy_cmd_e         cmd;
   logic [7:0]       tx_byte;
   logic             ack_tx;
   logic             phy_done;
   logic [7:0]       rx_byte;
   logic             ack_rx;
   logic [TOTW-1:0]  fetched;
   logic             seq_fin;
   logic             seq_err;
   logic [6:0]       addr7;

   function automatic logic [TOTW-1:0] set_cfg(input dflt_set_e s);
      case (s)
         SET_B:   return SET_B_CFG;
         SET_C:   return SET_C_CFG;
         SET_D:   return SET_D_CFG;
         default: return SET_A_CFG;
      endcase
   endfunction

   strap_latch #(.STRAP_W(3)) strap_i0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (strap_i),
      .mode_o  (mode)
   );

   assign addr7 = mode.alt_addr ? ADDR_SEL1 : ADDR_SEL0;
   assign start = (st_q == T_INIT) && mode.fetch;

   boot_fetch_seq #(.NBYTES(NBYTES), .WORD_ADDR(WORD_ADDR)) seq_i0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .addr7_i    (addr7),
      .cmd_o      (cmd),
      .tx_byte_o  (tx_byte),
      .ack_tx_o   (ack_tx),
      .phy_done_i (phy_done),
      .rx_byte_i  (rx_byte),
      .ack_rx_i   (ack_rx),
      .cfg_o      (fetched),
      .fin_o      (seq_fin),
      .err_o      (seq_err)
   );

   i2c_byte_phy #(.QTR_CYC(QTR_CYC)) phy_i0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_i     (cmd),
      .tx_byte_i (tx_byte),
      .ack_tx_i  (ack_tx),
      .done_o    (phy_done),
      .rx_byte_o (rx_byte),
      .ack_rx_o  (ack_rx),
      .scl_low_o (scl_pull_o),
      .sda_low_o (sda_pull_o),
      .sda_i     (sda_i)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= T_INIT;
         cfg_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         case (st_q)
            T_INIT: begin
               if (mode.fetch) begin
                  st_q <= T_FETCH;
               end else begin
                  cfg_q  <= set_cfg(mode.set);
                  done_q <= 1'b1;
                  st_q   <= T_DONE;
               end
            end
            T_FETCH: begin
               if (seq_fin) begin
                  cfg_q  <= seq_err ? SET_A_CFG : fetched;
                  err_q  <= seq_err;
                  done_q <= 1'b1;
                  st_q   <= T_DONE;
               end
            end
            default: ;
         endcase
      end
   end

   // Register unpack: register 0 holds the most significant word
   logic [CFG_W-1:0] regs [NREG];
   generate
      for (genvar g = 0; g < NREG; g++) begin : g_unpack
         assign regs[g] = cfg_q[TOTW-1-g*CFG_W -: CFG_W];
      end
   endgenerate

   assign cfg0_o         = regs[0];
   assign cfg1_o         = regs[1];
   assign cfg2_o         = regs[2];
   assign cfg3_o         = regs[3];
   assign done_o         = done_q;
   assign err_o          = err_q;
   assign cpu_start_en_o = done_q;

   p_dflt_quick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == T_INIT && !mode.fetch) |=> done_q);

   p_dflt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode.fetch |-> (!scl_pull_o && !sda_pull_o));

   p_err_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (done_q && cfg_q == SET_A_CFG));

   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> (done_q && $stable(cfg_q) && cpu_start_en_o));

endmodule

// File: tb/boot_strap_loader_tb_top.sv
`timescale 1ns/1ps
module boot_strap_loader_tb_top;

   localparam int QTR = 4;
   localparam logic [127:0] EXP_A = 128'h8000_0000_0000_1100_0000_0000_2000_0001;
   localparam logic [127:0] EXP_B = 128'h4000_0000_0001_2200_0000_0000_2000_0002;
   localparam logic [127:0] EXP_C = 128'hC000_0000_0002_3300_0000_0000_4000_0004;
   localparam logic [127:0] EXP_D = 128'h2000_0000_0003_4400_0000_0000_4000_0008;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  strap = 3'b010;
   logic        scl_pull, sda_pull;
   logic [31:0] c0, c1, c2, c3;
   logic        done, err, cpu_en;
   logic        slv_low = 1'b0;
   wire         scl_w = ~scl_pull;
   wire         sda_w = ~(sda_pull | slv_low);

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   boot_strap_loader #(.QTR_CYC(QTR)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_i(strap),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .sda_i(sda_w),
      .cfg0_o(c0), .cfg1_o(c1), .cfg2_o(c2), .cfg3_o(c3),
      .done_o(done), .err_o(err), .cpu_start_en_o(cpu_en)
   );

   // ---------------- behavioural EEPROM ----------------
   typedef enum {E_IDLE, E_ADDR, E_WORD, E_WAIT, E_READ} eep_e;
   eep_e       est = E_IDLE;
   logic [6:0] slv_addr = 7'h54;
   bit         slv_nack_word = 0;
   int         bc = 0;
   logic [7:0] sh = 0;
   logic [7:0] ptr = 0;
   bit         hit = 0, rw = 0, mack = 0;
   int         n_start = 0, n_stop = 0, n_rd = 0, n_mack = 0, n_mnack = 0;
   int         word_seen = -1;
   int         last_rise = 0, min_per = 1000000;

   function automatic logic [7:0] mem_at(input int a);
      return 8'((a * 37 + 11) ^ (a << 4));
   endfunction

   always @(negedge sda_w) if (scl_w === 1'b1 && rst_n) begin
      n_start++; est = E_ADDR; bc = 0; slv_low = 1'b0;
   end
   always @(posedge sda_w) if (scl_w === 1'b1 && rst_n) begin
      n_stop++; est = E_IDLE; slv_low = 1'b0;
   end
   always @(posedge scl_w) begin
      if (rst_n && est != E_IDLE) begin
         if (cyc - last_rise < min_per && last_rise != 0) min_per = cyc - last_rise;
         last_rise = cyc;
      end
      if (est == E_ADDR || est == E_WORD) begin
         if (bc < 8) sh = {sh[6:0], sda_w};
         bc++;
      end else if (est == E_READ) begin
         if (bc == 8) mack = ~sda_w;
         bc++;
      end
   end
   always @(negedge scl_w) begin
      case (est)
         E_ADDR: if (bc == 8) begin
            hit = (sh[7:1] == slv_addr); rw = sh[0];
            slv_low = hit;
         end else if (bc == 9) begin
            slv_low = 1'b0; bc = 0;
            if (!hit) est = E_IDLE;
            else if (rw) begin est = E_READ; slv_low = ~mem_at(int'(ptr))[7]; end
            else est = E_WORD;
         end
         E_WORD: if (bc == 8) begin
            word_seen = int'(sh);
            slv_low = ~slv_nack_word;
         end else if (bc == 9) begin
            slv_low = 1'b0; bc = 0; ptr = sh;
            est = slv_nack_word ? E_IDLE : E_WAIT;
         end
         E_READ: if (bc >= 1 && bc <= 7) begin
            slv_low = ~mem_at(int'(ptr))[7-bc];
         end else if (bc == 8) begin
            slv_low = 1'b0; n_rd++;
         end else if (bc == 9) begin
            bc = 0;
            if (mack) begin n_mack++; ptr++; slv_low = ~mem_at(int'(ptr))[7]; end
            else begin n_mnack++; est = E_IDLE; end
         end
         default: ;
      endcase
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] eep_image();
      logic [127:0] v = '0;
      for (int i = 0; i < 16; i++) v = {v[119:0], mem_at(i)};
      return v;
   endfunction

   task automatic reset_with(input logic [2:0] s);
      rst_n = 1'b0; strap = s;
      est = E_IDLE; slv_low = 1'b0; bc = 0;
      n_start = 0; n_stop = 0; n_rd = 0; n_mack = 0; n_mnack = 0;
      word_seen = -1; last_rise = 0; min_per = 1000000;
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
      #5;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_default(input logic [2:0] s, input logic [127:0] exp, input string tag);
      reset_with(s);
      chk(done == 1'b0 && cpu_en == 1'b0, {tag, " R3/R7 low before edge"}, {126'd0, done, cpu_en}, 0);
      @(posedge clk); #5;
      chk(done == 1'b1 && err == 1'b0, {tag, " R3 done one edge after release"}, {126'd0, done, err}, 2);
      chk({c0, c1, c2, c3} == exp, {tag, " R2 selected set"}, {c0, c1, c2, c3}, exp);
      repeat (50) @(posedge clk); #5;
      chk(n_start == 0 && scl_w && sda_w, {tag, " R3 bus untouched"}, n_start, 0);
   endtask

   task automatic t_fetch(input logic [2:0] s, input logic [6:0] a);
      logic [127:0] img;
      slv_addr = a; slv_nack_word = 0;
      reset_with(s);
      repeat (100) @(posedge clk); #5;
      chk(cpu_en == 1'b0 && done == 1'b0, "R7 start gated mid-fetch", {126'd0, done, cpu_en}, 0);
      strap = 3'b111;   // late change must be ignored
      wait_done();
      img = eep_image();
      chk({c0, c1, c2, c3} == img && err == 1'b0, "R5 packed image", {c0, c1, c2, c3}, img);
      chk(c0[31:24] == mem_at(0), "R5 first byte in cfg0 top", c0[31:24], mem_at(0));
      chk(n_rd == 16 && n_mack == 15 && n_mnack == 1, "R4 16 bytes, last NACK",
          n_rd * 256 + n_mack * 16 + n_mnack, 16 * 256 + 15 * 16 + 1);
      chk(n_start == 2 && n_stop == 1 && word_seen == 0, "R4 restart and word 0",
          n_start * 16 + n_stop, 2 * 16 + 1);
      chk(min_per == 4 * QTR, "R8 SCL period", min_per, 4 * QTR);
      chk(cpu_en == 1'b1, "R7 start enabled after done", cpu_en, 1);
      repeat (200) @(posedge clk); #5;
      chk({c0, c1, c2, c3} == img && done, "R1 late strap ignored", {c0, c1, c2, c3}, img);
   endtask

   task automatic t_nack_addr();
      slv_addr = 7'h50; slv_nack_word = 0;
      reset_with(3'b000);   // asks 0x54, nobody there
      wait_done();
      chk(err == 1'b1 && {c0, c1, c2, c3} == EXP_A, "R6 address NACK fallback",
          {c0, c1, c2, c3}, EXP_A);
      chk(n_stop == 1 && n_rd == 0, "R6 STOP after address NACK", n_stop * 16 + n_rd, 16);
   endtask

   task automatic t_nack_word();
      slv_addr = 7'h54; slv_nack_word = 1;
      reset_with(3'b000);
      wait_done();
      chk(err == 1'b1 && {c0, c1, c2, c3} == EXP_A && cpu_en, "R6 word NACK fallback",
          {c0, c1, c2, c3}, EXP_A);
      chk(n_start == 1 && n_stop == 1, "R6 no restart after word NACK", n_start, 1);
      slv_nack_word = 0;
   endtask

   task automatic t_strap_edge();
      rst_n = 1'b0; strap = 3'b100;
      repeat (3) @(posedge clk);
      #2 strap = 3'b101;   // after the last low-reset edge
      #3 rst_n = 1'b1;
      @(posedge clk); #5;
      chk({c0, c1, c2, c3} == EXP_B, "R1 capture at last reset edge", {c0, c1, c2, c3}, EXP_B);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_default(3'b010, EXP_A, "set A");
      t_default(3'b100, EXP_B, "set B");
      t_default(3'b101, EXP_C, "set C");
      t_default(3'b111, EXP_D, "set D");
      t_default(3'b110, EXP_A, "spare code");
      t_strap_edge();
      t_fetch(3'b000, 7'h54);
      t_fetch(3'b001, 7'h50);
      t_fetch(3'b011, 7'h50);
      t_nack_addr();
      t_nack_word();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule